// File: doc/BRIEF.md
# Boundary-Scan Register Chain

This block is a serial chain of boundary-scan cells that sits between a device's core logic and its pin buffers. Every cell has a shift stage and an update latch. The shift stages can load a parallel value, or they can pass test data one position per test clock from the serial input toward the serial output. The update latch holds a copy of the shift stage, so the values the cell drives stay fixed while new data moves through the chain.

Each cell serves one signal. Output cells serve signals that go from the core to an output pin. Input cells serve signals that go from an input pin to the core. A TAP controller outside this block supplies the capture, shift and update strobes and a two-bit mode select. The block applies them to the chain.

In transparent mode and in sample mode the cells have no effect on the signals. In external-test mode the output pins take their values from the update latches. In internal-test mode the core inputs take their values from the update latches.

Top module: `bscan_chain`

## Requirements
- R1: An active-low test-logic reset clears every shift stage and every update latch. While reset is low, both paths are transparent whatever the mode select is. A mode chosen after reset is released drives zeros from the cleared latches.
- R2: With mode select 2'b00 (transparent), pin_out equals core_out and core_in equals pin_in, bit for bit.
- R3: A clock with capture_en high loads every shift stage with its parallel value. Output cell i (cells 0 to N_OUT-1) loads core_out[i]. Input cell N_OUT+j loads pin_in[j].
- R4: A clock with shift_en high and capture_en low moves each stage one position toward cell 0. Cell N-1 takes tdi. tdo always shows the stage of cell 0, so the captured cell k appears on tdo before the (k+1)-th shift clock.
- R5: The update latches change only on a clock with update_en high, and they then copy the shift stages. Scanning in new data does not change pin_out or core_in.
- R6: With mode select 2'b10 (external test), pin_out[i] equals update latch i, and core_in still follows pin_in.
- R7: With mode select 2'b11 (internal test), core_in[j] equals update latch N_OUT+j, and pin_out still follows core_out.
- R8: With mode select 2'b01 (sample), both paths stay transparent while capture, shift and update all operate.
- R9: When capture_en and shift_en are high together, the capture is performed and the shift is dropped. A clock with no strobe leaves the shift stages unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low test-logic reset |
| mode_sel | input | 2 | 00 transparent, 01 sample, 10 external test, 11 internal test |
| capture_en | input | 1 | Parallel-load strobe for the shift stages |
| shift_en | input | 1 | Serial-advance strobe |
| update_en | input | 1 | Copy the shift stages into the update latches |
| tdi | input | 1 | Serial test data entering cell N-1 |
| core_out | input | N_OUT | Signals from the core toward the output pins |
| pin_in | input | N_IN | Signals arriving at the input pins |
| pin_out | output | N_OUT | Drive toward the output pin buffers |
| core_in | output | N_IN | Signals delivered to the core inputs |
| tdo | output | 1 | Serial test data from cell 0 |

## Verification
The chain is captured and scanned with several parallel patterns. These are alternating nibbles, complementary values on the core side and the pin side, and asymmetric serial words. A bit routed to the wrong cell, or a capture source swapped between core and pin, shows up in the tdo stream at a known position.

Each mode is entered with update latches whose contents differ from both core_out and pin_in. This separates a path driven from a latch from a transparent path. Checking the outputs after a full scan but before the update shows whether the latches held.

A cycle with capture and shift both high, followed by idle cycles, tests the strobe priority and the hold behaviour. A reset pulse in the middle of a test mode shows that the latches clear and that the paths revert to transparent.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_SAMPLE = 2'b01,
    MODE_EXTEST = 2'b10,
    MODE_INTEST = 2'b11
  } bs_mode_e;

  // Next value of a shift stage: capture wins over shift, otherwise hold.
  function automatic logic stage_next(input logic cap, input logic shf,
                                      input logic par, input logic ser,
                                      input logic cur);
    if (cap)      return par;
    else if (shf) return ser;
    else          return cur;
  endfunction

  // Effective mode: reset forces the transparent setting.
  function automatic bs_mode_e mode_eff(input logic rst_n, input logic [1:0] sel);
    return rst_n ? bs_mode_e'(sel) : MODE_NORMAL;
  endfunction

endpackage

// File: rtl/bsc_cell.sv
module bsc_cell
  import bscan_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cap_en,
  input  logic shf_en,
  input  logic upd_en,
  input  logic par_in,
  input  logic ser_in,
  output logic stage_q,
  output logic latch_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
    end else begin
      stage_q <= stage_next(cap_en, shf_en, par_in, ser_in, stage_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
    end else if (upd_en) begin
      latch_q <= stage_q;
    end
  end

endmodule

// File: rtl/bsc_path_mux.sv
module bsc_path_mux
  import bscan_pkg::*;
#(
  parameter int       W        = 4,
  parameter bs_mode_e ACTIVE_M = MODE_EXTEST
) (
  input  bs_mode_e       mode,
  input  logic [W-1:0]   func_in,
  input  logic [W-1:0]   test_in,
  output logic [W-1:0]   y
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign y[b] = (mode == ACTIVE_M) ? test_in[b] : func_in[b];
  end

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
  import bscan_pkg::*;
#(
  parameter int N_OUT = 4,
  parameter int N_IN  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic             capture_en,
  input  logic             shift_en,
  input  logic             update_en,
  input  logic             tdi,
  input  logic [N_OUT-1:0] core_out,
  input  logic [N_IN-1:0]  pin_in,
  output logic [N_OUT-1:0] pin_out,
  output logic [N_IN-1:0]  core_in,
  output logic             tdo
);

  localparam int N = N_OUT + N_IN;

  bs_mode_e     mode_q;
  logic [N-1:0] par_vec;
  logic [N-1:0] ser_vec;
  logic [N-1:0] sh_q;
  logic [N-1:0] upd_q;

  assign mode_q  = mode_eff(rst_n, mode_sel);
  assign par_vec = {pin_in, core_out};

  for (genvar k = 0; k < N; k++) begin : g_cell
    if (k == N - 1) begin : g_head
      assign ser_vec[k] = tdi;
    end else begin : g_link
      assign ser_vec[k] = sh_q[k+1];
    end

    bsc_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_en  (capture_en),
      .shf_en  (shift_en),
      .upd_en  (update_en),
      .par_in  (par_vec[k]),
      .ser_in  (ser_vec[k]),
      .stage_q (sh_q[k]),
      .latch_q (upd_q[k])
    );
  end

  assign tdo = sh_q[0];

  bsc_path_mux #(.W(N_OUT), .ACTIVE_M(MODE_EXTEST)) u_pin_mux (
    .mode    (mode_q),
    .func_in (core_out),
    .test_in (upd_q[N_OUT-1:0]),
    .y       (pin_out)
  );

  bsc_path_mux #(.W(N_IN), .ACTIVE_M(MODE_INTEST)) u_core_mux (
    .mode    (mode_q),
    .func_in (pin_in),
    .test_in (upd_q[N-1:N_OUT]),
    .y       (core_in)
  );

endmodule

// File: rtl/bscan_chain_chk.sv
module bscan_chain_chk #(
  parameter int N_OUT = 4,
  parameter int N_IN  = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [1:0]             mode_sel,
  input logic                   capture_en,
  input logic                   shift_en,
  input logic                   update_en,
  input logic                   tdi,
  input logic [N_OUT-1:0]       core_out,
  input logic [N_IN-1:0]        pin_in,
  input logic [N_OUT-1:0]       pin_out,
  input logic [N_IN-1:0]        core_in,
  input logic                   tdo,
  input logic [N_OUT+N_IN-1:0]  sh_q,
  input logic [N_OUT+N_IN-1:0]  upd_q
);

  localparam int N = N_OUT + N_IN;

  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |-> (upd_q == '0 && sh_q == '0 && pin_out == core_out && core_in == pin_in)); // R1
  AST_NORMAL_PASS: assert property (@(posedge clk) disable iff (!rst_n) (mode_sel == 2'b00) |-> (pin_out == core_out && core_in == pin_in)); // R2
  AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (!rst_n) capture_en |=> (sh_q == $past({pin_in, core_out}))); // R3
  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n) (shift_en && !capture_en) |=> (sh_q[N-2:0] == $past(sh_q[N-1:1]) && sh_q[N-1] == $past(tdi))); // R4
  AST_TDO_CELL0: assert property (@(posedge clk) disable iff (!rst_n) tdo == sh_q[0]); // R4
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !update_en |=> $stable(upd_q)); // R5
  AST_EXTEST_DRIVE: assert property (@(posedge clk) disable iff (!rst_n) (mode_sel == 2'b10) |-> (pin_out == upd_q[N_OUT-1:0] && core_in == pin_in)); // R6
  AST_INTEST_APPLY: assert property (@(posedge clk) disable iff (!rst_n) (mode_sel == 2'b11) |-> (core_in == upd_q[N-1:N_OUT] && pin_out == core_out)); // R7
  AST_SAMPLE_PASS: assert property (@(posedge clk) disable iff (!rst_n) (mode_sel == 2'b01) |-> (pin_out == core_out && core_in == pin_in)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!capture_en && !shift_en) |=> $stable(sh_q)); // R9

endmodule

bind bscan_chain bscan_chain_chk #(.N_OUT(N_OUT), .N_IN(N_IN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_sel   (mode_sel),
  .capture_en (capture_en),
  .shift_en   (shift_en),
  .update_en  (update_en),
  .tdi        (tdi),
  .core_out   (core_out),
  .pin_in     (pin_in),
  .pin_out    (pin_out),
  .core_in    (core_in),
  .tdo        (tdo),
  .sh_q       (sh_q),
  .upd_q      (upd_q)
);

// File: tb/bscan_chain_tb_top.sv
`timescale 1ns/1ps
module bscan_chain_tb_top;

  localparam int NO = 4;
  localparam int NI = 4;
  localparam int N  = NO + NI;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    mode_sel;
  logic          capture_en, shift_en, update_en, tdi;
  logic [NO-1:0] core_out;
  logic [NI-1:0] pin_in;
  logic [NO-1:0] pin_out;
  logic [NI-1:0] core_in;
  logic          tdo;

  int n_chk = 0;
  int n_err = 0;

  logic  exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  bscan_chain #(.N_OUT(NO), .N_IN(NI)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .capture_en(capture_en),
    .shift_en(shift_en), .update_en(update_en), .tdi(tdi), .core_out(core_out),
    .pin_in(pin_in), .pin_out(pin_out), .core_in(core_in), .tdo(tdo)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops one expected tdo bit for every pure shift cycle.
  always @(negedge clk) begin
    #5;
    if (rst_n === 1'b1 && shift_en === 1'b1 && capture_en === 1'b0) begin
      if (exp_q.size() == 0) begin
        chk("R4 unexpected shift", 8'h01, 8'h00);
      end else begin
        logic  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, {7'd0, tdo}, {7'd0, e});
      end
    end
  end

  // Driver: capture (optionally with shift), idle cycles, then N shift cycles.
  task automatic cap_scan(input logic [N-1:0] v, input logic [N-1:0] exp,
                          input bit both, input int idle, input string tag);
    @(negedge clk);
    capture_en = 1'b1;
    shift_en   = both;
    tdi        = 1'b1;
    @(negedge clk);
    capture_en = 1'b0;
    shift_en   = 1'b0;
    for (int i = 0; i < idle; i++) @(negedge clk);
    for (int k = 0; k < N; k++) begin
      exp_q.push_back(exp[k]);
      tag_q.push_back(tag);
    end
    shift_en = 1'b1;
    for (int k = 0; k < N; k++) begin
      tdi = v[k];
      @(negedge clk);
    end
    shift_en = 1'b0;
    #5;
  endtask

  task automatic do_update();
    @(negedge clk);
    update_en = 1'b1;
    @(negedge clk);
    update_en = 1'b0;
    #5;
  endtask

  initial begin
    #(20 * 100000);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_sel = 2'b10; capture_en = 0; shift_en = 0; update_en = 0; tdi = 0;
    core_out = 4'hA; pin_in = 4'h5;
    repeat (3) @(negedge clk);
    #5;
    // R1: in reset, external-test select is overridden
    chk("R1 pin_out in reset", {4'd0, pin_out}, {4'd0, core_out});
    chk("R1 tdo in reset", {7'd0, tdo}, 8'h00);
    @(negedge clk); rst_n = 1'b1; #5;
    chk("R1 cleared latch drives pins", {4'd0, pin_out}, 8'h00);

    // R2: transparent mode, two patterns
    mode_sel = 2'b00; core_out = 4'h3; pin_in = 4'hC; #5;
    chk("R2 pin_out", {4'd0, pin_out}, 8'h03);
    chk("R2 core_in", {4'd0, core_in}, 8'h0C);
    core_out = 4'h9; pin_in = 4'h6; #5;
    chk("R2 pin_out b", {4'd0, pin_out}, 8'h09);
    chk("R2 core_in b", {4'd0, core_in}, 8'h06);

    // R3 R4 R8: sample mode capture and scan
    mode_sel = 2'b01; core_out = 4'h6; pin_in = 4'h9;
    cap_scan(8'hA5, 8'h96, 1'b0, 0, "R3 R4 capture/shift stream");
    chk("R8 sample pin_out", {4'd0, pin_out}, 8'h06);
    do_update();
    chk("R8 sample core_in after update", {4'd0, core_in}, 8'h09);
    chk("R8 sample pin_out after update", {4'd0, pin_out}, 8'h06);

    // R6: external test drives from latch (A5 -> low nibble 5)
    mode_sel = 2'b10; #5;
    chk("R6 pin_out from latch", {4'd0, pin_out}, 8'h05);
    chk("R6 core_in follows pin", {4'd0, core_in}, 8'h09);
    core_out = 4'h1; pin_in = 4'hE;
    cap_scan(8'h3C, 8'hE1, 1'b0, 0, "R3 R4 extest stream");
    chk("R5 pin_out held during scan", {4'd0, pin_out}, 8'h05);
    do_update();
    chk("R6 pin_out after update", {4'd0, pin_out}, 8'h0C);

    // R7: internal test, latch high nibble = 3
    mode_sel = 2'b11; #5;
    chk("R7 core_in from latch", {4'd0, core_in}, 8'h03);
    chk("R7 pin_out follows core", {4'd0, pin_out}, 8'h01);
    core_out = 4'h7; pin_in = 4'h2;
    cap_scan(8'h7E, 8'h27, 1'b0, 0, "R3 R4 intest stream");
    chk("R5 core_in held during scan", {4'd0, core_in}, 8'h03);
    do_update();
    chk("R7 core_in after update", {4'd0, core_in}, 8'h07);

    // R9: capture and shift together, then idle cycles hold the stages
    core_out = 4'hB; pin_in = 4'h4;
    cap_scan(8'h00, 8'h4B, 1'b1, 3, "R9 priority/hold stream");

    // R1: reset pulse in internal test
    @(negedge clk); rst_n = 1'b0; #5;
    chk("R1 core_in transparent in reset", {4'd0, core_in}, 8'h04);
    @(negedge clk); rst_n = 1'b1; #5;
    chk("R1 latch cleared after reset", {4'd0, core_in}, 8'h00);

    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) chk("R4 leftover expected bits", 8'(exp_q.size()), 8'h00);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule